// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast system clock into the timing enables that a serial channel needs. An accumulator divider scales the clock by a 10-bit step over 1024 to give a fractional tick. An integer prescaler then divides that tick into time quanta. A quanta counter groups a programmable number of quanta into one bit time. Each of the three stages drives a one-cycle strobe that the channel logic can use as a clock enable.

The prescaler can take its ticks from a second source instead of the fractional divider. That source is a trigger pin, and each synchronized rising edge on the pin counts as one tick. The block has one configuration strobe. It captures the step, the prescaler value, the quanta count and the source select together, and it restarts every counter so that bit timing begins fresh from that edge.

Top module: `baud_tq_gen`

## Requirements
- R1: After reset, and while the captured step is 0 and the source is the fractional divider, `frac_tick`, `tq_tick` and `bit_tick` stay 0.
- R2: Count the clock edges after the capturing edge as n = 1, 2, 3 and so on, and let s be the step (1 to 1023). `frac_tick` is 1 in the cycle after edge n exactly when floor(n*s/1024) differs from floor((n-1)*s/1024).
- R3: Let P be the prescaler value (`cfg_pre`). Number the input ticks from the capturing edge. `tq_tick` is 1 in the cycle after the edge that consumes every (P+1)-th input tick, and 0 otherwise. With the fractional source, the input tick for an edge is the `frac_tick` value held just before that edge.
- R4: Let O be the quanta count field (`cfg_osr`), which holds quanta per bit minus one. `bit_tick` is 1 in the cycle after the edge that consumes every (O+1)-th `tq_tick` pulse.
- R5: An edge that samples `cfg_load` = 1 captures all four configuration inputs and clears every counter and every strobe. In the cycle after that edge all three strobes are 0, and the bit count starts again from zero.
- R6: With `cfg_src` = 1 (external), the prescaler counts only synchronized rising edges of `ext_trig`. Fractional ticks are ignored, although `frac_tick` keeps running. With `cfg_src` = 0, `ext_trig` has no effect.
- R7: A rising edge of `ext_trig` that is first sampled high at edge A counts as an input tick at edge A+2. With P = 0, `tq_tick` is 1 in the cycle after edge A+2, and with O = 0 as well, `bit_tick` is 1 one cycle later.
- R8: Every strobe is driven by a register and lasts exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Capture the configuration and restart all counters |
| cfg_step | input | 10 | Fractional step, rate = clock * step / 1024 |
| cfg_pre | input | 10 | Prescaler value, divides by value plus one |
| cfg_osr | input | 5 | Time quanta per bit minus one |
| cfg_src | input | 1 | Prescaler source: 0 fractional divider, 1 external trigger |
| ext_trig | input | 1 | Asynchronous external trigger input |
| frac_tick | output | 1 | One-cycle fractional divider strobe |
| tq_tick | output | 1 | One-cycle time-quantum strobe |
| bit_tick | output | 1 | One-cycle bit-time strobe |

## Verification
Two things can fall in the same clock cycle: a configuration restart, and a quantum or bit strobe that is already in flight in the pipeline. The bench provokes this by starting a new configuration at a random point in a running stream, often when the fractional divider is pulsing almost every cycle. A cycle model built from R2 to R5 expects the restart to win and every strobe to read 0 in the next cycle. It also expects the bit count to start again at zero, and it compares all three strobes on every cycle after the restart.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned FRAC_W_DEF = 10;
  localparam int unsigned PRE_W_DEF  = 10;
  localparam int unsigned OSR_W_DEF  = 5;

  typedef enum logic {
    SRC_FRAC = 1'b0,
    SRC_EXT  = 1'b1
  } src_sel_e;
endpackage

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int unsigned W = baud_pkg::FRAC_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] step,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= sum[W-1:0];
      tick_o <= sum[W];
    end
  end

  // a zero step can never carry out of the accumulator
  assert_zero_step_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> !tick_o);

  // with a step below half range, two carries cannot come back to back
  assert_no_double_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !step[W-1] && $stable(step)) |=> !tick_o);
endmodule

// File: rtl/baud_edge_sync.sv
module baud_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[1:0], async_i};
  end

  always_comb rise_o = sh_q[1] & ~sh_q[2];

  assert_rise_single_R7: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/baud_div_cnt.sv
module baud_div_cnt #(
  parameter int unsigned W = baud_pkg::PRE_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  always_comb wrap = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= en && wrap;
      if (en) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit);

  // R8: an output strobe always answers one consumed input tick
  assert_tick_from_input_R8: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(en && !clr));
endmodule

// File: rtl/baud_tq_gen.sv
module baud_tq_gen #(
  parameter int unsigned FRAC_W = baud_pkg::FRAC_W_DEF,
  parameter int unsigned PRE_W  = baud_pkg::PRE_W_DEF,
  parameter int unsigned OSR_W  = baud_pkg::OSR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [FRAC_W-1:0] cfg_step,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic [OSR_W-1:0]  cfg_osr,
  input  logic              cfg_src,
  input  logic              ext_trig,
  output logic              frac_tick,
  output logic              tq_tick,
  output logic              bit_tick
);
  import baud_pkg::*;

  logic [FRAC_W-1:0] step_q;
  logic [PRE_W-1:0]  pre_q;
  logic [OSR_W-1:0]  osr_q;
  src_sel_e          src_q;
  logic              ext_rise;
  logic              pre_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      pre_q  <= '0;
      osr_q  <= '0;
      src_q  <= SRC_FRAC;
    end else if (cfg_load) begin
      step_q <= cfg_step;
      pre_q  <= cfg_pre;
      osr_q  <= cfg_osr;
      src_q  <= src_sel_e'(cfg_src);
    end
  end

  baud_frac_div #(.W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .clr(cfg_load), .step(step_q), .tick_o(frac_tick)
  );

  baud_edge_sync u_sync (
    .clk(clk), .rst(rst), .async_i(ext_trig), .rise_o(ext_rise)
  );

  always_comb pre_in = (src_q == SRC_EXT) ? ext_rise : frac_tick;

  baud_div_cnt #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(cfg_load), .en(pre_in), .limit(pre_q), .tick_o(tq_tick)
  );

  baud_div_cnt #(.W(OSR_W)) u_tq (
    .clk(clk), .rst(rst), .clr(cfg_load), .en(tq_tick), .limit(osr_q), .tick_o(bit_tick)
  );

  assert_load_clears_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (!frac_tick && !tq_tick && !bit_tick));

  assert_ext_ignores_frac_R6: assert property (@(posedge clk) disable iff (rst)
    (src_q == SRC_EXT && !ext_rise) |=> !tq_tick);

  assert_bit_after_tq_R4: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> $past(tq_tick));
endmodule

// File: tb/baud_tq_gen_bench.sv
module baud_tq_gen_bench;
  localparam int FW = 10;
  localparam int PW = 10;
  localparam int OW = 5;

  logic clk = 1'b0, rst = 1'b1, cfg_load = 1'b0, cfg_src = 1'b0, ext_trig = 1'b0;
  logic [FW-1:0] cfg_step = '0;
  logic [PW-1:0] cfg_pre = '0;
  logic [OW-1:0] cfg_osr = '0;
  logic frac_tick, tq_tick, bit_tick;

  int vectors = 0, errors = 0;
  bit done = 0;

  // cycle model state, from the requirement statements
  longint m_n;
  int m_s, m_p, m_o, m_fc, m_qc;
  bit m_src, e_f, e_q, e_b;
  int c_f, c_q, c_b;

  always #5 clk = ~clk;

  baud_tq_gen u_baud_tq_gen (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_step(cfg_step), .cfg_pre(cfg_pre),
    .cfg_osr(cfg_osr), .cfg_src(cfg_src), .ext_trig(ext_trig),
    .frac_tick(frac_tick), .tq_tick(tq_tick), .bit_tick(bit_tick)
  );

  function automatic bit frac_due(longint n, int s);
    return ((n * s) >> FW) != (((n - 1) * s) >> FW);
  endfunction

  task automatic check1(string req, string name, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, name, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, string name, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic cmp_all(string req);
    check1(req, "frac_tick", frac_tick, e_f);
    check1(req, "tq_tick", tq_tick, e_q);
    check1(req, "bit_tick", bit_tick, e_b);
  endtask

  task automatic model_clear();
    m_n = 0; m_fc = 0; m_qc = 0; e_f = 0; e_q = 0; e_b = 0;
  endtask

  task automatic model_edge();
    bit in_t, nf, nq, nb;
    m_n++;
    in_t = (m_src == 0) ? e_f : 1'b0;
    nf = (m_s == 0) ? 1'b0 : frac_due(m_n, m_s);
    nq = 0;
    if (in_t) begin
      m_fc++;
      if (m_fc == m_p + 1) begin m_fc = 0; nq = 1; end
    end
    nb = 0;
    if (e_q) begin
      m_qc++;
      if (m_qc == m_o + 1) begin m_qc = 0; nb = 1; end
    end
    e_f = nf; e_q = nq; e_b = nb;
  endtask

  // called at a negedge; returns at a negedge
  task automatic load_cfg(int s, int p, int o, bit src);
    cfg_step = FW'(s); cfg_pre = PW'(p); cfg_osr = OW'(o); cfg_src = src;
    cfg_load = 1'b1;
    @(posedge clk);
    m_s = s; m_p = p; m_o = o; m_src = src;
    model_clear();
    @(negedge clk);
    cfg_load = 1'b0;
    cmp_all("R5");
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      cmp_all(req);
    end
  endtask

  task automatic run_count(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_f += int'(frac_tick); c_q += int'(tq_tick); c_b += int'(bit_tick);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_s = 0; m_p = 0; m_o = 0; m_src = 0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset
    run(20, "R1");

    // directed corners of R2 R3 R4
    load_cfg(1023, 0, 0, 0);
    run(200, "R2 R3 R4 R8");
    load_cfg(1, 0, 0, 0);
    run(2100, "R2 R8");
    load_cfg(512, 3, 15, 0);
    run(600, "R3 R4");
    load_cfg(700, 1023, 0, 0);
    run(300, "R3");
    // R6: ext_trig toggling has no effect in fractional mode
    load_cfg(1023, 1, 1, 0);
    for (int k = 0; k < 10; k++) begin
      ext_trig = ~ext_trig;
      run(7, "R6");
    end
    ext_trig = 1'b0;
    run(5, "R6");

    // random configurations, each restarted mid-stream (R5 against in-flight strobes)
    for (int it = 0; it < 24; it++) begin
      int s, p, o;
      s = ($urandom % 4 == 0) ? 1 + int'($urandom % 1023) : 512 + int'($urandom % 512);
      p = int'($urandom % 6);
      o = int'($urandom % 8);
      load_cfg(s, p, o, 0);
      run(150 + int'($urandom % 300), "R2 R3 R4 R5");
    end

    // R6: external source ignores fractional ticks
    load_cfg(1023, 2, 1, 1);
    c_f = 0; c_q = 0; c_b = 0;
    run_count(100);
    check_int("R6", "tq count without trigger", c_q, 0);
    check_int("R6", "frac keeps running", (c_f > 90) ? 1 : 0, 1);
    c_q = 0; c_b = 0;
    for (int k = 0; k < 12; k++) begin
      ext_trig = 1'b1;
      run_count(4);
      ext_trig = 1'b0;
      run_count(4);
    end
    run_count(6);
    check_int("R6", "tq count from 12 edges", c_q, 4);
    check_int("R6", "bit count from 12 edges", c_b, 2);

    // R7: exact latency of an external edge
    load_cfg(1, 0, 0, 1);
    ext_trig = 1'b1;
    @(posedge clk); @(negedge clk);
    check1("R7", "tq_tick after A", tq_tick, 1'b0);
    @(posedge clk); @(negedge clk);
    check1("R7", "tq_tick after A+1", tq_tick, 1'b0);
    @(posedge clk); @(negedge clk);
    check1("R7", "tq_tick after A+2", tq_tick, 1'b1);
    check1("R7", "bit_tick after A+2", bit_tick, 1'b0);
    @(posedge clk); @(negedge clk);
    check1("R7", "bit_tick after A+3", bit_tick, 1'b1);
    check1("R8", "tq_tick single cycle", tq_tick, 1'b0);
    @(posedge clk); @(negedge clk);
    check1("R8", "bit_tick single cycle", bit_tick, 1'b0);
    ext_trig = 1'b0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule